// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor sequential access to local packet memory through a single data port. The host sets a 16-bit transfer address and a 16-bit remaining-byte count with byte-wide register writes. Each later strobe on the data port moves either one byte or one little-endian 16-bit word between the port and memory. After every access the address moves forward, wraps at the end of the receive ring, and the remaining count goes down. When the count runs out, a completion flag rises in an interrupt status register.

Memory has two windows: a small identification area at the bottom of the address space and a packet RAM window higher up. Accesses outside both windows do not disturb memory, and reads there return all-ones. The data port always shows the value at the current address. A read strobe consumes that value and steps the pointer.

Top module: `rdma_engine`

## Requirements
- R1: After reset, the status register (offset 0x3) reads 0x80, and the address (offsets 0x4/0x5) and count (offsets 0x6/0x7) read 0.
- R2: Writes to offsets 0x4/0x5 load the low/high byte of the transfer address, and writes to 0x6/0x7 load the low/high byte of the count. Reads at the same offsets return the current values.
- R3: Bit 0 of the configuration register (offset 0x8) selects word mode, where each access moves 2 bytes. When it is clear, each access moves 1 byte.
- R4: Each access adds the access size to the address. If the result equals the ring-end page (offset 0x2) times 256, the address is reloaded with the ring-first page (offset 0x1) times 256.
- R5: When an access starts with a count no larger than the access size, the count becomes 0 and status bit 6 is set. Otherwise the count drops by the access size.
- R6: A data-port write while the count is 0 changes neither memory, the address, the count nor the status.
- R7: A command write (offset 0x0) with bit 0 clear clears status bit 7. If bit 3 or bit 4 is also set and the count is 0, status bit 6 is set.
- R8: Mapped memory is addresses 0..PROM_BYTES-1 and RAM_BASE..RAM_BASE+RAM_BYTES-1. Writes elsewhere are discarded. Reads elsewhere return 0x00FF in byte mode and 0xFFFF in word mode. In byte mode the data-port bits 15:8 read 0.
- R9: A word access uses the address with bit 0 forced to 0. The byte at the even address is on bits 7:0 and the byte at the odd address is on bits 15:8.
- R10: A status write clears each of bits 6:0 written as 1 and never clears bit 7. A completion in the same cycle as a clear of bit 6 leaves bit 6 set.
- R11: A data-port read is not gated by the count. With count 0, a read still advances the address and sets status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe (consumes dp_rdata) |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data at the current address |

## Verification
Two updates can land on the status register in the same cycle: a host write clearing bit 6, and a data-port read whose count expiry sets bit 6. The bench raises both strobes in one cycle with a count of 1 and expects bit 6 to remain set. Separately, a reference model predicts address, count, status and port data across constrained-random sequences. These sequences mix byte and word accesses, ring wraps, unmapped addresses and zero-count writes.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int AW = 16;
    localparam int DW = 16;

    typedef enum logic [3:0] {
        OFS_CMD        = 4'h0,
        OFS_RING_FIRST = 4'h1,
        OFS_RING_LAST  = 4'h2,
        OFS_STATUS     = 4'h3,
        OFS_ADDR_LO    = 4'h4,
        OFS_ADDR_HI    = 4'h5,
        OFS_CNT_LO     = 4'h6,
        OFS_CNT_HI     = 4'h7,
        OFS_CFG        = 4'h8
    } reg_ofs_e;

    localparam int CMD_HALT = 0;
    localparam int CMD_RD   = 3;
    localparam int CMD_WR   = 4;
    localparam int ST_DONE  = 6;
    localparam int ST_RESET = 7;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic          done;
    } ptr_step_t;

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] off;
    } region_t;

    function automatic ptr_step_t step_ptr(
        input logic [AW-1:0] addr,
        input logic [AW-1:0] cnt,
        input logic [AW-1:0] size,
        input logic [7:0]    first_pg,
        input logic [7:0]    last_pg
    );
        ptr_step_t r;
        r.addr = addr + size;
        if (r.addr == {last_pg, 8'h00})
            r.addr = {first_pg, 8'h00};
        if (cnt <= size) begin
            r.cnt  = '0;
            r.done = 1'b1;
        end else begin
            r.cnt  = cnt - size;
            r.done = 1'b0;
        end
        return r;
    endfunction

    function automatic region_t region_map(
        input logic [AW-1:0] a,
        input int            prom_bytes,
        input int            ram_base,
        input int            ram_bytes
    );
        region_t r;
        int ai;
        ai = int'(a);
        if (ai < prom_bytes) begin
            r.hit = 1'b1;
            r.off = a;
        end else if (ai >= ram_base && ai < ram_base + ram_bytes) begin
            r.hit = 1'b1;
            r.off = AW'(ai - ram_base + prom_bytes);
        end else begin
            r.hit = 1'b0;
            r.off = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] cmd,
    output logic [7:0] ring_first,
    output logic [7:0] ring_last,
    output logic [7:0] cfg
);

    reg_ofs_e ofs;
    assign ofs = reg_ofs_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd        <= 8'h01;
            ring_first <= '0;
            ring_last  <= '0;
            cfg        <= '0;
        end else if (reg_wr) begin
            case (ofs)
                OFS_CMD:        cmd        <= reg_wdata;
                OFS_RING_FIRST: ring_first <= reg_wdata;
                OFS_RING_LAST:  ring_last  <= reg_wdata;
                OFS_CFG:        cfg        <= reg_wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
    import rdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          dp_go,
    input  logic          word_mode,
    input  logic [7:0]    ring_first,
    input  logic [7:0]    ring_last,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] cnt,
    output logic [7:0]    status
);

    reg_ofs_e      ofs;
    logic [AW-1:0] size;
    ptr_step_t     stp;
    logic [AW-1:0] addr_n, cnt_n;
    logic [7:0]    st_n;

    assign ofs  = reg_ofs_e'(reg_addr);
    assign size = word_mode ? AW'(2) : AW'(1);
    assign stp  = step_ptr(addr, cnt, size, ring_first, ring_last);

    always_comb begin
        addr_n = addr;
        cnt_n  = cnt;
        st_n   = status;
        if (dp_go) begin
            addr_n = stp.addr;
            cnt_n  = stp.cnt;
        end
        if (reg_wr) begin
            case (ofs)
                OFS_ADDR_LO: addr_n[7:0]  = reg_wdata;
                OFS_ADDR_HI: addr_n[15:8] = reg_wdata;
                OFS_CNT_LO:  cnt_n[7:0]   = reg_wdata;
                OFS_CNT_HI:  cnt_n[15:8]  = reg_wdata;
                OFS_STATUS:  st_n[6:0]    = st_n[6:0] & ~reg_wdata[6:0];
                OFS_CMD: begin
                    if (!reg_wdata[CMD_HALT]) begin
                        st_n[ST_RESET] = 1'b0;
                        if ((reg_wdata[CMD_RD] || reg_wdata[CMD_WR]) && cnt == '0)
                            st_n[ST_DONE] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (dp_go && stp.done)
            st_n[ST_DONE] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            cnt    <= '0;
            status <= 8'h80;
        end else begin
            addr   <= addr_n;
            cnt    <= cnt_n;
            status <= st_n;
        end
    end

endmodule

// File: rtl/rdma_mem.sv
module rdma_mem
    import rdma_pkg::*;
#(
    parameter int PROM_BYTES = 32,
    parameter int RAM_BASE   = 16384,
    parameter int RAM_BYTES  = 1024
) (
    input  logic          clk,
    input  logic          word_mode,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = PROM_BYTES + RAM_BYTES;
    localparam int IDXW  = $clog2(DEPTH);

    logic [7:0]      store [DEPTH];
    logic [AW-1:0]   base;
    region_t         reg_hit;
    logic [IDXW-1:0] idx_lo, idx_hi;

    assign base    = word_mode ? {addr[AW-1:1], 1'b0} : addr;
    assign reg_hit = region_map(base, PROM_BYTES, RAM_BASE, RAM_BYTES);
    assign idx_lo  = reg_hit.off[IDXW-1:0];
    assign idx_hi  = {reg_hit.off[IDXW-1:1], 1'b1};

    always_ff @(posedge clk) begin
        if (wr_en && reg_hit.hit) begin
            store[idx_lo] <= wdata[7:0];
            if (word_mode)
                store[idx_hi] <= wdata[15:8];
        end
    end

    always_comb begin
        if (!reg_hit.hit)
            rdata = word_mode ? 16'hFFFF : 16'h00FF;
        else if (word_mode)
            rdata = {store[idx_hi], store[idx_lo]};
        else
            rdata = {8'h00, store[idx_lo]};
    end

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int PROM_BYTES = 32,
    parameter int RAM_BASE   = 16384,
    parameter int RAM_BYTES  = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dp_wr,
    input  logic        dp_rd,
    input  logic [15:0] dp_wdata,
    output logic [15:0] dp_rdata
);

    logic [7:0]    cmd, ring_first, ring_last, cfg, status;
    logic [AW-1:0] addr, cnt;
    logic          word_mode, dp_wr_ok, dp_go;
    reg_ofs_e      ofs;

    assign word_mode = cfg[0];
    assign dp_wr_ok  = dp_wr && (cnt != '0);
    assign dp_go     = dp_rd || dp_wr_ok;
    assign ofs       = reg_ofs_e'(reg_addr);

    rdma_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .cmd        (cmd),
        .ring_first (ring_first),
        .ring_last  (ring_last),
        .cfg        (cfg)
    );

    rdma_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .dp_go      (dp_go),
        .word_mode  (word_mode),
        .ring_first (ring_first),
        .ring_last  (ring_last),
        .addr       (addr),
        .cnt        (cnt),
        .status     (status)
    );

    rdma_mem #(
        .PROM_BYTES (PROM_BYTES),
        .RAM_BASE   (RAM_BASE),
        .RAM_BYTES  (RAM_BYTES)
    ) u_mem (
        .clk       (clk),
        .word_mode (word_mode),
        .addr      (addr),
        .wr_en     (dp_wr_ok),
        .wdata     (dp_wdata),
        .rdata     (dp_rdata)
    );

    always_comb begin
        case (ofs)
            OFS_CMD:        reg_rdata = cmd;
            OFS_RING_FIRST: reg_rdata = ring_first;
            OFS_RING_LAST:  reg_rdata = ring_last;
            OFS_STATUS:     reg_rdata = status;
            OFS_ADDR_LO:    reg_rdata = addr[7:0];
            OFS_ADDR_HI:    reg_rdata = addr[15:8];
            OFS_CNT_LO:     reg_rdata = cnt[7:0];
            OFS_CNT_HI:     reg_rdata = cnt[15:8];
            OFS_CFG:        reg_rdata = cfg;
            default:        reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        dp_wr,
    input logic        dp_rd,
    input logic [15:0] addr,
    input logic [15:0] cnt,
    input logic [7:0]  status,
    input logic        word_mode,
    input logic [7:0]  ring_first,
    input logic [7:0]  ring_last
);

    logic [15:0] sz;
    assign sz = word_mode ? 16'd2 : 16'd1;

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (addr == 16'h0 && cnt == 16'h0 && status[7]));

    assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && !reg_wr && (addr + sz) == {ring_last, 8'h00})
        |=> addr == {$past(ring_first), 8'h00});

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && !reg_wr && cnt > sz) |=> cnt == $past(cnt) - $past(sz));

    assert_done_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && !reg_wr && cnt <= sz) |=> (cnt == 16'h0 && status[6]));

    assert_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (dp_wr && !dp_rd && !reg_wr && cnt == 16'h0)
        |=> (cnt == 16'h0 && $stable(addr) && $stable(status)));

    assert_zero_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h0 && !reg_wdata[0]
         && (reg_wdata[3] || reg_wdata[4]) && cnt == 16'h0)
        |=> (status[6] && !status[7]));

endmodule

bind rdma_engine rdma_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .dp_wr      (dp_wr),
    .dp_rd      (dp_rd),
    .addr       (addr),
    .cnt        (cnt),
    .status     (status),
    .word_mode  (word_mode),
    .ring_first (ring_first),
    .ring_last  (ring_last)
);

// File: tb/rdma_engine_tb.sv
`timescale 1ns/1ps
module rdma_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_wr = 1'b0;
    logic        dp_rd = 1'b0;
    logic [15:0] dp_wdata = 16'h0;
    logic [15:0] dp_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rdma_engine u_dut (
        .clk (clk), .rst (rst),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dp_wr (dp_wr), .dp_rd (dp_rd), .dp_wdata (dp_wdata), .dp_rdata (dp_rdata)
    );

    // reference model state
    logic [7:0]  mm [0:1055];
    logic [15:0] m_addr, m_cnt;
    logic [7:0]  m_st, m_cmd, m_first, m_last, m_cfg;

    function automatic int slot(input int a);
        if (a >= 0 && a <= 31) return a;
        if (a >= 16'h4000 && a <= 16'h43FF) return a - 16'h4000 + 32;
        return -1;
    endfunction

    function automatic logic [15:0] m_peek();
        int s;
        if (m_cfg[0]) begin
            s = slot(int'(m_addr) & 32'hFFFE);
            if (s < 0) return 16'hFFFF;
            return {mm[s+1], mm[s]};
        end
        s = slot(int'(m_addr));
        if (s < 0) return 16'h00FF;
        return {8'h00, mm[s]};
    endfunction

    function automatic logic [7:0] m_reg(input logic [3:0] o);
        case (o)
            4'h0: return m_cmd;
            4'h1: return m_first;
            4'h2: return m_last;
            4'h3: return m_st;
            4'h4: return m_addr[7:0];
            4'h5: return m_addr[15:8];
            4'h6: return m_cnt[7:0];
            4'h7: return m_cnt[15:8];
            4'h8: return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reg(input logic [3:0] o, input logic [7:0] v);
        case (o)
            4'h0: begin
                m_cmd = v;
                if (!v[0]) begin
                    m_st[7] = 1'b0;
                    if ((v[3] || v[4]) && m_cnt == 0) m_st[6] = 1'b1;
                end
            end
            4'h1: m_first = v;
            4'h2: m_last = v;
            4'h3: m_st = m_st & ~(v & 8'h7F);
            4'h4: m_addr[7:0] = v;
            4'h5: m_addr[15:8] = v;
            4'h6: m_cnt[7:0] = v;
            4'h7: m_cnt[15:8] = v;
            4'h8: m_cfg = v;
            default: ;
        endcase
    endtask

    task automatic model_acc(input bit is_wr, input logic [15:0] d);
        int sz, s;
        logic [15:0] nxt;
        sz = m_cfg[0] ? 2 : 1;
        if (is_wr && m_cnt == 0) return;
        if (is_wr) begin
            if (sz == 2) begin
                s = slot(int'(m_addr) & 32'hFFFE);
                if (s >= 0) begin mm[s] = d[7:0]; mm[s+1] = d[15:8]; end
            end else begin
                s = slot(int'(m_addr));
                if (s >= 0) mm[s] = d[7:0];
            end
        end
        nxt = m_addr + 16'(sz);
        if (nxt == {m_last, 8'h00}) nxt = {m_first, 8'h00};
        m_addr = nxt;
        if (int'(m_cnt) <= sz) begin m_cnt = 0; m_st[6] = 1'b1; end
        else m_cnt = m_cnt - 16'(sz);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wreg(input logic [3:0] o, input logic [7:0] v);
        reg_addr = o; reg_wdata = v; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
        model_reg(o, v);
    endtask

    task automatic dpw(input logic [15:0] d);
        dp_wdata = d; dp_wr = 1'b1;
        tick();
        dp_wr = 1'b0;
        model_acc(1'b1, d);
    endtask

    task automatic dpr(input string tag);
        #1;
        chk(dp_rdata, m_peek(), tag);
        dp_rd = 1'b1;
        tick();
        dp_rd = 1'b0;
        model_acc(1'b0, 16'h0);
    endtask

    task automatic creg(input logic [3:0] o, input string tag);
        reg_addr = o;
        #1;
        chk({8'h00, reg_rdata}, {8'h00, m_reg(o)}, tag);
    endtask

    task automatic set16(input logic [3:0] lo, input logic [15:0] v);
        wreg(lo, v[7:0]);
        wreg(lo + 4'h1, v[15:8]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd7351);
        m_addr = 0; m_cnt = 0; m_st = 8'h80; m_cmd = 8'h01;
        m_first = 0; m_last = 0; m_cfg = 0;
        for (int i = 0; i < 1056; i++) mm[i] = 8'h00;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0080, "R1 status");
        creg(4'h4, "R1 addr lo"); creg(4'h5, "R1 addr hi");
        creg(4'h6, "R1 cnt lo");  creg(4'h7, "R1 cnt hi");

        // R10 status write never clears bit 7
        wreg(4'h3, 8'hFF);
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0080, "R10 bit7 kept");
        // R7 halted command keeps bit 7, running command clears it
        wreg(4'h0, 8'h01); creg(4'h3, "R7 halt cmd");
        wreg(4'h0, 8'h22);
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0000, "R7 bit7 cleared");
        wreg(4'h0, 8'h0A);
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0040, "R7 zero-count cmd");
        wreg(4'h3, 8'h40);

        // fill both windows in word mode (R3, R9)
        wreg(4'h8, 8'h01);
        set16(4'h4, 16'h0000); set16(4'h6, 16'd32);
        for (int i = 0; i < 16; i++) dpw(16'($urandom));
        set16(4'h4, 16'h4000); set16(4'h6, 16'd1024);
        for (int i = 0; i < 512; i++) dpw(16'($urandom));
        creg(4'h3, "R5 fill done"); creg(4'h4, "R3 word step addr");

        // R2 address readback
        set16(4'h4, 16'h1234);
        reg_addr = 4'h4; #1; chk({8'h00, reg_rdata}, 16'h0034, "R2 addr lo");
        reg_addr = 4'h5; #1; chk({8'h00, reg_rdata}, 16'h0012, "R2 addr hi");

        // R9 word write at odd address
        set16(4'h4, 16'h4011); set16(4'h6, 16'd2);
        dpw(16'hBEEF);
        wreg(4'h8, 8'h00);
        set16(4'h4, 16'h4010); #1; chk(dp_rdata, 16'h00EF, "R9 low byte");
        set16(4'h4, 16'h4011); #1; chk(dp_rdata, 16'h00BE, "R9 high byte");

        // R8 unmapped region
        set16(4'h4, 16'h0100); #1; chk(dp_rdata, 16'h00FF, "R8 byte unmapped");
        wreg(4'h8, 8'h01); #1; chk(dp_rdata, 16'hFFFF, "R8 word unmapped");
        set16(4'h6, 16'd4); dpw(16'h1111);
        set16(4'h4, 16'h0100); #1; chk(dp_rdata, 16'hFFFF, "R8 write discarded");
        wreg(4'h8, 8'h00);

        // R6 write ignored with zero count
        set16(4'h6, 16'd0); set16(4'h4, 16'h4000);
        dpw(16'h00A5);
        reg_addr = 4'h4; #1; chk({8'h00, reg_rdata}, 16'h0000, "R6 addr unchanged");
        chk(dp_rdata, m_peek(), "R6 memory unchanged");

        // R4 ring wrap
        wreg(4'h1, 8'h40); wreg(4'h2, 8'h41);
        set16(4'h4, 16'h40FF); set16(4'h6, 16'd5);
        dpw(16'h0077);
        reg_addr = 4'h5; #1; chk({8'h00, reg_rdata}, 16'h0040, "R4 wrap hi");
        reg_addr = 4'h4; #1; chk({8'h00, reg_rdata}, 16'h0000, "R4 wrap lo");

        // R5 word mode completion with odd count
        wreg(4'h3, 8'h7F);
        wreg(4'h8, 8'h01); set16(4'h4, 16'h4020); set16(4'h6, 16'd3);
        dpr("R5 read a");
        reg_addr = 4'h6; #1; chk({8'h00, reg_rdata}, 16'h0001, "R5 cnt after step");
        dpr("R5 read b");
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0040, "R5 done set");

        // R11 read with zero count
        wreg(4'h3, 8'h40);
        dpr("R11 read at zero");
        reg_addr = 4'h4; #1; chk({8'h00, reg_rdata}, 16'h0026, "R11 addr advanced");
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0040, "R11 done set");

        // R10 clear and completion in the same cycle
        wreg(4'h3, 8'h40); wreg(4'h8, 8'h00); set16(4'h6, 16'd1);
        reg_addr = 4'h3; reg_wdata = 8'h40; reg_wr = 1'b1; dp_rd = 1'b1;
        tick();
        reg_wr = 1'b0; dp_rd = 1'b0;
        model_reg(4'h3, 8'h40); model_acc(1'b0, 16'h0);
        reg_addr = 4'h3; #1; chk({8'h00, reg_rdata}, 16'h0040, "R10 set beats clear");

        // constrained random phase
        wreg(4'h1, 8'h40); wreg(4'h2, 8'h44);
        for (int k = 0; k < 600; k++) begin
            int op, sel;
            op = $urandom_range(0, 9);
            case (op)
                0: begin
                    sel = $urandom_range(0, 2);
                    if (sel == 0) set16(4'h4, 16'($urandom_range(0, 40)));
                    else if (sel == 1) set16(4'h4, 16'(16'h4000 + $urandom_range(0, 1040)));
                    else set16(4'h4, 16'($urandom));
                end
                1: set16(4'h6, 16'($urandom_range(0, 20)));
                2: wreg(4'h8, 8'($urandom_range(0, 1)));
                3, 4, 5: dpw(16'($urandom));
                6, 7, 8: dpr("R4 R5 R8 R9 random read");
                default: begin
                    if ($urandom_range(0, 1) == 0) wreg(4'h3, 8'($urandom));
                    else wreg(4'h0, 8'($urandom) & 8'hFE);
                end
            endcase
            if (k % 20 == 0) begin
                creg(4'h3, "R10 random status");
                creg(4'h4, "R2 random addr lo"); creg(4'h5, "R2 random addr hi");
                creg(4'h6, "R5 random cnt lo");  creg(4'h7, "R5 random cnt hi");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule